// File: doc/BRIEF.md
# Coprocessor Escape Opcode Snooper

This block sits beside a host CPU and listens to its instruction-fetch bus. It has no handshake with the host for instructions. Instead it keeps a shadow byte queue that follows the host's prefetch queue. Fetched bytes are pushed into the shadow queue. Bytes are popped when the host's 2-bit queue-status hint says a byte was taken. The shadow queue is emptied when the hint reports a flush. Decoding works on bytes taken from the head of this shadow queue, not on bus fetch timing, so prefetching never confuses which instruction is executing.

The first byte of an instruction is checked for the escape tag. If the tag is present, the block keeps the three operation bits from that byte and decodes the second (mode/register/memory) byte. A register operand completes at once. For a memory operand, the block captures the first data word that the host itself reads. When the operand is wider than one word, the block raises a bus request, reads the remaining words at consecutive word addresses once granted, and drops the request as soon as the last word arrives.

The finished instruction is presented as a one-cycle strobe with its fields. The host cannot be stalled by this block, so the result interface has no ready and no back-pressure; a consumer must take the fields in the strobe cycle. They stay stable until the next strobe. At reset a strap selects the host type, which fixes the shadow queue depth and the number of bytes accepted per fetch.

Top module: `esc_snoop`

## Requirements
- R1: A first-byte take (status 01) whose byte has bits [7:3] equal to 5'b11011 starts a decode. Any other first byte produces no `dec_valid`, and the bytes taken after it are ignored.
- R2: `dec_op` carries bits [2:0] of the escape byte. From the second byte, `dec_mod` = bits [7:6], `dec_reg` = bits [5:3] and `dec_rm` = bits [2:0].
- R3: When the second byte has mode 2'b11, `dec_valid` is high in the cycle after the cycle in which that byte is taken. `dec_mem` is 0, `dec_words` is 0 and no bus request is made.
- R4: When the mode is not 2'b11, further subsequent-byte takes (displacement) are ignored. The operand's first word is the `mem_data` of the first cycle with `mem_valid` high after the second byte, and `dec_mem` is 1.
- R5: The operand word count follows `dec_op[1:0]`: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 5. It is reported on `dec_words` for memory operands.
- R6: For counts above 1, `bus_req` rises. Once `bus_gnt` is high, each remaining word is read by a one-cycle `rd_en` at `rd_addr` = host address + 2, + 4, and so on, waiting for `mem_valid` between reads. Word i is placed at `dec_operand[16i +: 16]`, and unused words are 0.
- R7: `bus_req` is low in the cycle after the last word's `mem_valid`, and `dec_valid` rises one cycle later.
- R8: `wide_strap` is sampled while `rst_n` is low. With 1, the queue depth is 6 and a fetch pushes `fetch_data[7:0]` and then `fetch_data[15:8]`. With 0, the depth is 4 and only `fetch_data[7:0]` is pushed.
- R9: Bytes fetched while the shadow queue is at its depth are discarded.
- R10: Queue status 00 is no-op, 01 first byte taken, 10 flush, 11 subsequent byte taken. A flush empties the queue, drops any fetch in the same cycle, abandons a pending decode, and has `bus_req` low and no `dec_valid` on the next cycle.
- R11: Taken bytes leave the shadow queue in fetch order, and a take while the queue is empty has no effect.
- R12: After reset, `dec_valid`, `bus_req` and `rd_en` are 0.
- R13: A first-byte take while a decode is pending abandons that decode and starts on the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_strap | input | 1 | Host type strap, sampled during reset |
| fetch_valid | input | 1 | Host instruction fetch cycle |
| fetch_data | input | 16 | Fetched instruction bytes |
| qs | input | 2 | Host queue status hint |
| mem_valid | input | 1 | Data word present on the data bus |
| mem_addr | input | 20 | Address of the host's data read |
| mem_data | input | 16 | Data bus word |
| bus_gnt | input | 1 | Bus grant from host |
| bus_req | output | 1 | Bus request while fetching operand words |
| rd_en | output | 1 | One-cycle read issued by this block |
| rd_addr | output | 20 | Address of this block's read |
| dec_valid | output | 1 | Decoded instruction strobe |
| dec_op | output | 3 | Operation bits from the escape byte |
| dec_mod | output | 2 | Mode field |
| dec_reg | output | 3 | Register field |
| dec_rm | output | 3 | Register/memory field |
| dec_mem | output | 1 | Memory operand present |
| dec_words | output | 3 | Operand word count (0 for register) |
| dec_operand | output | 80 | Captured operand words |

## Verification
A shadow queue that is out of step with the host appears at once as a wrong `dec_op`/`dec_rm` or a missing or extra `dec_valid` on the very next decode. The sweep over all 256 first bytes, and the depth and overflow sequences, expose this within two takes. A wrong word count or address step shows at the strobe as operand words that do not match the arithmetic memory pattern, or as a read count different from count minus one. A stuck bus request shows up one cycle after the last word or after a flush.

// File: rtl/esc_snoop_pkg.sv
package esc_snoop_pkg;
  localparam logic [1:0] QS_NOP   = 2'b00;
  localparam logic [1:0] QS_FIRST = 2'b01;
  localparam logic [1:0] QS_FLUSH = 2'b10;
  localparam logic [1:0] QS_NEXT  = 2'b11;
  localparam logic [4:0] ESC_TAG  = 5'b11011;

  typedef enum logic [1:0] {D_IDLE, D_MODRM, D_HOSTRD, D_OWNRD} dstate_t;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_ISSUE, F_WAIT} fstate_t;

  // operand size class -> word count
  function automatic logic [2:0] words_for(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/esc_shadow_queue.sv
module esc_shadow_queue #(
  parameter int QMAX = 6,
  parameter int NARROW_DEPTH = 4,
  parameter int DW = 16,
  localparam int CW = $clog2(QMAX + 1),
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [7:0]    head,
  output logic          head_ok,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] depth
);
  logic [7:0]    q  [QMAX];
  logic [7:0]    nq [QMAX];
  logic [CW-1:0] cnt, ncnt;

  assign depth   = wide ? CW'(QMAX) : CW'(NARROW_DEPTH);
  assign head    = q[0];
  assign head_ok = (cnt != '0);
  assign occ     = cnt;

  always_comb begin
    for (int i = 0; i < QMAX; i++) nq[i] = q[i];
    ncnt = cnt;
    if (flush) begin
      ncnt = '0;
    end else begin
      if (pop && cnt != '0) begin
        for (int i = 0; i < QMAX - 1; i++) nq[i] = q[i+1];
        ncnt = cnt - 1'b1;
      end
      if (push_valid) begin
        for (int b = 0; b < NB; b++) begin
          if ((wide || b == 0) && ncnt < depth) begin
            for (int p = 0; p < QMAX; p++)
              if (CW'(p) == ncnt) nq[p] = push_data[8*b +: 8];
            ncnt = ncnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < QMAX; i++) q[i] <= '0;
    end else begin
      cnt <= ncnt;
      for (int i = 0; i < QMAX; i++) q[i] <= nq[i];
    end
  end
endmodule

// File: rtl/esc_operand_fetch.sv
module esc_operand_fetch import esc_snoop_pkg::*; #(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int MAXW = 5,
  localparam int NW = $clog2(MAXW + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [AW-1:0]            base,
  input  logic [NW-1:0]            count,
  input  logic                     abort,
  input  logic                     bus_gnt,
  input  logic                     mem_valid,
  input  logic [DW-1:0]            mem_data,
  output logic                     bus_req,
  output logic                     rd_en,
  output logic [AW-1:0]            rd_addr,
  output logic                     done,
  output logic [(MAXW-1)*DW-1:0]   words
);
  fstate_t                  fs;
  logic [AW-1:0]            addr_q;
  logic [NW-1:0]            left, idx;
  logic [(MAXW-1)*DW-1:0]   wbuf_q;

  assign bus_req = (fs != F_IDLE);
  assign rd_en   = (fs == F_ISSUE);
  assign rd_addr = addr_q;
  assign words   = wbuf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs     <= F_IDLE;
      addr_q <= '0;
      left   <= '0;
      idx    <= '0;
      wbuf_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        fs <= F_IDLE;
      end else begin
        case (fs)
          F_IDLE: if (start) begin
            fs     <= F_REQ;
            addr_q <= base;
            left   <= count;
            idx    <= '0;
            wbuf_q <= '0;
          end
          F_REQ:   if (bus_gnt) fs <= F_ISSUE;
          F_ISSUE: fs <= F_WAIT;
          F_WAIT: if (mem_valid) begin
            for (int k = 0; k < MAXW - 1; k++)
              if (idx == NW'(k)) wbuf_q[k*DW +: DW] <= mem_data;
            idx    <= idx + 1'b1;
            left   <= left - 1'b1;
            addr_q <= addr_q + AW'(DW / 8);
            if (left == NW'(1)) begin
              fs   <= F_IDLE;
              done <= 1'b1;
            end else begin
              fs <= F_ISSUE;
            end
          end
          default: fs <= F_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/esc_decode.sv
module esc_decode import esc_snoop_pkg::*; #(
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int MAXW = 5,
  localparam int NW = $clog2(MAXW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             qs,
  input  logic [7:0]             head,
  input  logic                   head_ok,
  input  logic                   mem_valid,
  input  logic [AW-1:0]          mem_addr,
  input  logic [DW-1:0]          mem_data,
  input  logic                   fetch_done,
  input  logic [(MAXW-1)*DW-1:0] fetch_words,
  output logic                   fetch_start,
  output logic [AW-1:0]          fetch_base,
  output logic [NW-1:0]          fetch_count,
  output logic                   fetch_abort,
  output logic                   dec_valid,
  output logic [2:0]             dec_op,
  output logic [1:0]             dec_mod,
  output logic [2:0]             dec_reg,
  output logic [2:0]             dec_rm,
  output logic                   dec_mem,
  output logic [NW-1:0]          dec_words,
  output logic [MAXW*DW-1:0]     dec_operand
);
  dstate_t       st;
  logic [2:0]    op_q;
  logic [7:0]    modrm_q;
  logic [DW-1:0] w0_q;
  logic [NW-1:0] nwords;
  logic          take_first, take_next, flush;

  assign take_first  = (qs == QS_FIRST) && head_ok;
  assign take_next   = (qs == QS_NEXT) && head_ok;
  assign flush       = (qs == QS_FLUSH);
  assign nwords      = NW'(words_for(op_q[1:0]));
  assign fetch_start = (st == D_HOSTRD) && !flush && !take_first && mem_valid && (nwords > NW'(1));
  assign fetch_base  = mem_addr + AW'(DW / 8);
  assign fetch_count = nwords - 1'b1;
  assign fetch_abort = (st == D_OWNRD) && (flush || take_first);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= D_IDLE;
      op_q        <= '0;
      modrm_q     <= '0;
      w0_q        <= '0;
      dec_valid   <= 1'b0;
      dec_op      <= '0;
      dec_mod     <= '0;
      dec_reg     <= '0;
      dec_rm      <= '0;
      dec_mem     <= 1'b0;
      dec_words   <= '0;
      dec_operand <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (flush) begin
        st <= D_IDLE;
      end else if (take_first) begin
        op_q <= head[2:0];
        st   <= (head[7:3] == ESC_TAG) ? D_MODRM : D_IDLE;
      end else begin
        case (st)
          D_MODRM: if (take_next) begin
            modrm_q <= head;
            if (head[7:6] == 2'b11) begin
              dec_valid   <= 1'b1;
              dec_op      <= op_q;
              dec_mod     <= head[7:6];
              dec_reg     <= head[5:3];
              dec_rm      <= head[2:0];
              dec_mem     <= 1'b0;
              dec_words   <= '0;
              dec_operand <= '0;
              st          <= D_IDLE;
            end else begin
              st <= D_HOSTRD;
            end
          end
          D_HOSTRD: if (mem_valid) begin
            w0_q <= mem_data;
            if (nwords == NW'(1)) begin
              dec_valid   <= 1'b1;
              dec_op      <= op_q;
              dec_mod     <= modrm_q[7:6];
              dec_reg     <= modrm_q[5:3];
              dec_rm      <= modrm_q[2:0];
              dec_mem     <= 1'b1;
              dec_words   <= nwords;
              dec_operand <= {{((MAXW-1)*DW){1'b0}}, mem_data};
              st          <= D_IDLE;
            end else begin
              st <= D_OWNRD;
            end
          end
          D_OWNRD: if (fetch_done) begin
            dec_valid   <= 1'b1;
            dec_op      <= op_q;
            dec_mod     <= modrm_q[7:6];
            dec_reg     <= modrm_q[5:3];
            dec_rm      <= modrm_q[2:0];
            dec_mem     <= 1'b1;
            dec_words   <= nwords;
            dec_operand <= {fetch_words, w0_q};
            st          <= D_IDLE;
          end
          default: st <= D_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/esc_snoop.sv
module esc_snoop import esc_snoop_pkg::*; #(
  parameter int QMAX = 6,
  parameter int NARROW_DEPTH = 4,
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int MAXW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wide_strap,
  input  logic                       fetch_valid,
  input  logic [DW-1:0]              fetch_data,
  input  logic [1:0]                 qs,
  input  logic                       mem_valid,
  input  logic [AW-1:0]              mem_addr,
  input  logic [DW-1:0]              mem_data,
  input  logic                       bus_gnt,
  output logic                       bus_req,
  output logic                       rd_en,
  output logic [AW-1:0]              rd_addr,
  output logic                       dec_valid,
  output logic [2:0]                 dec_op,
  output logic [1:0]                 dec_mod,
  output logic [2:0]                 dec_reg,
  output logic [2:0]                 dec_rm,
  output logic                       dec_mem,
  output logic [$clog2(MAXW+1)-1:0]  dec_words,
  output logic [MAXW*DW-1:0]         dec_operand
);
  localparam int NW = $clog2(MAXW + 1);
  localparam int CW = $clog2(QMAX + 1);

  logic                   wide_q;
  logic [7:0]             q_head;
  logic                   q_head_ok;
  logic [CW-1:0]          q_occ, q_depth;
  logic                   f_start, f_abort, f_done;
  logic [AW-1:0]          f_base;
  logic [NW-1:0]          f_count;
  logic [(MAXW-1)*DW-1:0] f_words;

  // host type strap is followed only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) wide_q <= wide_strap;
  end

  esc_shadow_queue #(.QMAX(QMAX), .NARROW_DEPTH(NARROW_DEPTH), .DW(DW)) u_queue (
    .clk(clk), .rst_n(rst_n), .wide(wide_q),
    .push_valid(fetch_valid), .push_data(fetch_data),
    .pop((qs == QS_FIRST) || (qs == QS_NEXT)), .flush(qs == QS_FLUSH),
    .head(q_head), .head_ok(q_head_ok), .occ(q_occ), .depth(q_depth)
  );

  esc_decode #(.DW(DW), .AW(AW), .MAXW(MAXW)) u_decode (
    .clk(clk), .rst_n(rst_n), .qs(qs), .head(q_head), .head_ok(q_head_ok),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .fetch_done(f_done), .fetch_words(f_words),
    .fetch_start(f_start), .fetch_base(f_base), .fetch_count(f_count), .fetch_abort(f_abort),
    .dec_valid(dec_valid), .dec_op(dec_op), .dec_mod(dec_mod), .dec_reg(dec_reg),
    .dec_rm(dec_rm), .dec_mem(dec_mem), .dec_words(dec_words), .dec_operand(dec_operand)
  );

  esc_operand_fetch #(.DW(DW), .AW(AW), .MAXW(MAXW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(f_start), .base(f_base), .count(f_count),
    .abort(f_abort), .bus_gnt(bus_gnt), .mem_valid(mem_valid), .mem_data(mem_data),
    .bus_req(bus_req), .rd_en(rd_en), .rd_addr(rd_addr), .done(f_done), .words(f_words)
  );
endmodule

// File: rtl/esc_snoop_chk.sv
module esc_snoop_chk import esc_snoop_pkg::*; #(
  parameter int QMAX = 6,
  parameter int MAXW = 5,
  localparam int CW = $clog2(QMAX + 1),
  localparam int RC = $clog2(MAXW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    qs,
  input logic [7:0]    head,
  input logic          head_ok,
  input logic          dec_valid,
  input logic [2:0]    dec_op,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          rd_en,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] depth
);
  logic          last_esc;
  logic [2:0]    last_op;
  logic [RC-1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_esc <= 1'b0;
      last_op  <= '0;
      rd_cnt   <= '0;
    end else begin
      if (qs == QS_FLUSH) last_esc <= 1'b0;
      else if (qs == QS_FIRST && head_ok) begin
        last_esc <= (head[7:3] == ESC_TAG);
        last_op  <= head[2:0];
      end
      if (!bus_req) rd_cnt <= '0;
      else if (rd_en) rd_cnt <= rd_cnt + 1'b1;
    end
  end

  // R9
  occ_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n) occ <= depth);
  // R1
  esc_only_chk: assert property (@(posedge clk) disable iff (!rst_n) dec_valid |-> last_esc);
  // R2
  op_match_chk: assert property (@(posedge clk) disable iff (!rst_n) dec_valid |-> dec_op == last_op);
  // R6
  rd_granted_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> (bus_req && bus_gnt));
  // R6
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !rd_en);
  // R6
  rd_budget_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_cnt <= RC'(MAXW - 1));
  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qs == QS_FLUSH) |=> (!bus_req && !dec_valid));
endmodule

bind esc_snoop esc_snoop_chk #(.QMAX(QMAX), .MAXW(MAXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .qs(qs), .head(q_head), .head_ok(q_head_ok),
  .dec_valid(dec_valid), .dec_op(dec_op), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .rd_en(rd_en), .occ(q_occ), .depth(q_depth)
);

// File: tb/esc_snoop_tb.sv
module esc_snoop_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_strap = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_data = '0;
  logic [1:0]  qs = 2'b00;
  logic        host_mv = 1'b0;
  logic [19:0] host_addr = '0;
  logic [15:0] host_data = '0;
  logic        resp_mv = 1'b0;
  logic [15:0] resp_data = '0;
  logic        mem_valid;
  logic [19:0] mem_addr;
  logic [15:0] mem_data;
  logic        bus_gnt = 1'b0;
  logic        bus_req, rd_en, dec_valid, dec_mem;
  logic [19:0] rd_addr;
  logic [2:0]  dec_op, dec_reg, dec_rm, dec_words;
  logic [1:0]  dec_mod;
  logic [79:0] dec_operand;

  int total = 0;
  int bad = 0;
  int rdcount = 0;
  bit finished = 0;

  assign mem_valid = host_mv | resp_mv;
  assign mem_data  = host_mv ? host_data : resp_data;
  assign mem_addr  = host_addr;

  always #5 clk = ~clk;

  esc_snoop u_dut (
    .clk(clk), .rst_n(rst_n), .wide_strap(wide_strap), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .qs(qs), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .bus_gnt(bus_gnt), .bus_req(bus_req), .rd_en(rd_en),
    .rd_addr(rd_addr), .dec_valid(dec_valid), .dec_op(dec_op), .dec_mod(dec_mod),
    .dec_reg(dec_reg), .dec_rm(dec_rm), .dec_mem(dec_mem), .dec_words(dec_words),
    .dec_operand(dec_operand)
  );

  function automatic logic [15:0] fmem(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic int nwords(input int sz);
    case (sz)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory model: grant follows request; each read answered two cycles later
  initial begin
    int delay = 0;
    logic [19:0] paddr = '0;
    forever begin
      @(negedge clk);
      resp_mv = 1'b0;
      if (delay > 0) begin
        delay--;
        if (delay == 0) begin
          resp_mv = 1'b1;
          resp_data = fmem(paddr);
        end
      end
      if (rd_en) begin
        paddr = rd_addr;
        delay = 2;
        rdcount++;
      end
      bus_gnt = bus_req;
    end
  end

  task automatic do_reset(input bit wide);
    rst_n = 1'b0;
    wide_strap = wide;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wide_strap = ~wide;
    @(negedge clk);
  endtask

  task automatic fetch(input logic [15:0] w);
    fetch_valid = 1'b1;
    fetch_data = w;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic step(input logic [1:0] s);
    qs = s;
    @(negedge clk);
    qs = 2'b00;
  endtask

  task automatic host_read(input logic [19:0] a);
    host_mv = 1'b1;
    host_addr = a;
    host_data = fmem(a);
    @(negedge clk);
    host_mv = 1'b0;
  endtask

  task automatic wait_dec(output bit got, output logic prev_req);
    int n = 0;
    prev_req = bus_req;
    while (!dec_valid && n < 200) begin
      prev_req = bus_req;
      @(negedge clk);
      n++;
    end
    got = dec_valid;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit got;
    logic prev;
    int quiet;
    do_reset(1'b1);
    // R12 reset state
    chk(!bus_req && !rd_en && !dec_valid, "R12", {bus_req, rd_en, dec_valid}, 0);

    // R1 R2 R3: every first byte, register-form second byte
    for (int b = 0; b < 256; b++) begin
      logic [7:0] fb, mr;
      bit esc;
      int r0;
      fb = 8'(b);
      mr = {2'b11, fb[2:0] ^ 3'b101, fb[5:3]};
      esc = (fb[7:3] == 5'b11011);
      r0 = rdcount;
      step(2'b10);
      fetch({mr, fb});
      step(2'b01);
      step(2'b11);
      chk(dec_valid == esc, "R1", dec_valid, esc);
      if (esc) begin
        chk(dec_op == fb[2:0] && dec_mod == 2'b11 && dec_reg == (fb[2:0] ^ 3'b101) && dec_rm == fb[5:3],
            "R2", {dec_op, dec_mod, dec_reg, dec_rm}, {fb[2:0], 2'b11, fb[2:0] ^ 3'b101, fb[5:3]});
        chk(!dec_mem && dec_words == 0 && !bus_req && rdcount == r0, "R3",
            {dec_mem, dec_words, bus_req}, 0);
      end
    end

    // R4 R5 R6 R7: memory forms across all operation codes and modes
    for (int op = 0; op < 8; op++) begin
      for (int md = 0; md < 3; md++) begin
        logic [7:0] e, mr;
        logic [19:0] a;
        int n, r0;
        e = 8'hD8 | 8'(op);
        mr = {2'(md), 3'(op) ^ 3'b010, 3'b110};
        a = 20'h02000 + 20'(op * 256 + md * 32);
        n = nwords(op % 4);
        step(2'b10);
        fetch({mr, e});
        fetch(16'h3322);
        step(2'b01);
        step(2'b11);
        for (int d = 0; d < md; d++) step(2'b11);
        chk(!dec_valid, "R4", dec_valid, 0);
        r0 = rdcount;
        host_read(a);
        wait_dec(got, prev);
        chk(got && dec_mem && dec_mod == 2'(md) && dec_reg == (3'(op) ^ 3'b010), "R4",
            {got, dec_mem, dec_mod, dec_reg}, {1'b1, 1'b1, 2'(md), 3'(op) ^ 3'b010});
        chk(int'(dec_words) == n, "R5", dec_words, n);
        for (int i = 0; i < 5; i++) begin
          logic [15:0] ex;
          ex = (i < n) ? fmem(a + 20'(2 * i)) : 16'h0;
          chk(dec_operand[16*i +: 16] == ex, "R6", dec_operand[16*i +: 16], ex);
        end
        chk(rdcount - r0 == n - 1, "R6", rdcount - r0, n - 1);
        if (n > 1) chk(!prev && !bus_req, "R7", {prev, bus_req}, 0);
      end
    end

    // R10: flush during own reads abandons the decode
    step(2'b10);
    fetch(16'h05DB);
    step(2'b01);
    step(2'b11);
    host_read(20'h04000);
    repeat (6) @(negedge clk);
    chk(bus_req, "R10", bus_req, 1);
    step(2'b10);
    chk(!bus_req && !dec_valid, "R10", {bus_req, dec_valid}, 0);
    quiet = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (dec_valid) quiet++;
    end
    chk(quiet == 0, "R10", quiet, 0);
    // R10: fetch in the flush cycle is dropped; R11: take on empty queue ignored
    qs = 2'b10;
    fetch(16'hC1D9);
    qs = 2'b00;
    step(2'b01);
    step(2'b11);
    chk(!dec_valid, "R10", dec_valid, 0);
    fetch(16'hC1D9);
    step(2'b01);
    step(2'b11);
    chk(dec_valid && dec_op == 3'd1 && dec_rm == 3'd1, "R11", {dec_valid, dec_op, dec_rm}, {1'b1, 3'd1, 3'd1});

    // R13: new first byte while a memory decode waits
    step(2'b10);
    fetch(16'h06DA);
    fetch(16'hEADD);
    step(2'b01);
    step(2'b11);
    step(2'b01);
    step(2'b11);
    chk(dec_valid && dec_op == 3'd5 && dec_reg == 3'd5 && dec_rm == 3'd2 && !dec_mem, "R13",
        {dec_valid, dec_op, dec_reg, dec_rm, dec_mem}, {1'b1, 3'd5, 3'd5, 3'd2, 1'b0});
    host_read(20'h05000);
    quiet = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (dec_valid || bus_req) quiet++;
    end
    chk(quiet == 0, "R13", quiet, 0);

    // R9 R11: wide depth 6, fourth fetch dropped
    step(2'b10);
    fetch(16'hC0D8);
    fetch(16'hC9D9);
    fetch(16'hD2DA);
    fetch(16'hC3DB);
    for (int k = 0; k < 3; k++) begin
      step(2'b01);
      step(2'b11);
      chk(dec_valid && dec_op == 3'(k) && dec_reg == 3'(k) && dec_rm == 3'(k), "R11",
          {dec_valid, dec_op, dec_reg, dec_rm}, {1'b1, 3'(k), 3'(k), 3'(k)});
    end
    fetch(16'hE4DC);
    step(2'b01);
    step(2'b11);
    chk(dec_valid && dec_op == 3'd4 && dec_rm == 3'd4, "R9", {dec_valid, dec_op, dec_rm}, {1'b1, 3'd4, 3'd4});

    // R8: narrow host, only the low byte of each fetch is kept
    do_reset(1'b0);
    chk(!bus_req && !rd_en && !dec_valid, "R12", {bus_req, rd_en, dec_valid}, 0);
    fetch(16'hC1DD);
    fetch(16'hFFC2);
    step(2'b01);
    step(2'b11);
    chk(dec_valid && dec_op == 3'd5 && dec_reg == 3'd0 && dec_rm == 3'd2, "R8",
        {dec_valid, dec_op, dec_reg, dec_rm}, {1'b1, 3'd5, 3'd0, 3'd2});

    // R9: narrow depth 4, fifth byte dropped
    step(2'b10);
    fetch(16'h00D9);
    fetch(16'h00C3);
    fetch(16'h00DA);
    fetch(16'h00C4);
    fetch(16'h00DB);
    for (int k = 1; k < 3; k++) begin
      step(2'b01);
      step(2'b11);
      chk(dec_valid && dec_op == 3'(k) && dec_rm == 3'(k + 2), "R8",
          {dec_valid, dec_op, dec_rm}, {1'b1, 3'(k), 3'(k + 2)});
    end
    fetch(16'h00C5);
    step(2'b01);
    step(2'b11);
    chk(!dec_valid, "R9", dec_valid, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule